// File: doc/BRIEF.md
# Variable-Length Instruction Length Predecoder

This block sits between a byte-wide instruction fetch stream and the instruction decoder. Bytes arrive one per accepted transfer on a valid/ready handshake. The first byte of each instruction is its opcode. The high bits of the opcode fix how many operand bytes follow, so the block gathers exactly that many bytes. It then presents the whole instruction at once: the opcode, the operand bytes, the total length, the byte address of the opcode, and a class that tells jump logic where the PC displacement comes from. For classes that take the displacement from operand bytes, the displacement value is also given, sign-extended.

A completed instruction is held at the output until the decoder accepts it, and no further fetch byte is taken in the meantime. A taken branch pulses `flush` together with the branch target address. This discards any partly gathered instruction and any instruction still waiting at the output. The next byte accepted becomes an opcode at the target address.

Top module: `ilen_predecode`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the first accepted byte is an opcode at address `RESET_ADDR` (default 0).
- R2: An opcode whose bits [7:5] are 000, or whose bits [7:6] are 01, forms a 1-byte instruction (`out_len` = 1).
- R3: An opcode whose bits [7:5] are 001 forms a 5-byte instruction (`out_len` = 5). The four following bytes appear in `out_operands` in arrival order, with the k-th operand byte (k = 0..3) at bits [8k+7:8k].
- R4: An opcode whose bits [7:6] are 10 forms a 2-byte instruction (`out_len` = 2). Bits 11 form a 3-byte instruction (`out_len` = 3). Operand bytes are placed as in R3.
- R5: Operand byte lanes beyond the instruction's length read as zero.
- R6: `out_disp_cls` is 0 when opcode bit 7 is 0 (stack), 1 for opcode bits [7:6] = 10 (first operand byte), 2 for bits [7:5] = 110 (first two operand bytes), and 3 for bits [7:5] = 111 (second operand byte).
- R7: `out_disp` is zero for class 0. For class 1 it is operand byte 0 read as a signed byte; for class 3 it is operand byte 1 read as a signed byte. For class 2 it is the signed 16-bit value {operand byte 0, operand byte 1}. Every value is sign-extended to `DISP_W` bits.
- R8: `out_addr` is the address of the opcode byte. The address advances by one for every accepted byte.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output fields stay unchanged and `in_ready` is 0. The cycle after an accepted output, `out_valid` is 0.
- R10: In a cycle with `flush` high, `in_ready` is 0. In the next cycle, `out_valid` is 0, any partly gathered instruction is dropped, and the next accepted byte is an opcode at address `flush_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Taken-branch flush pulse |
| flush_addr | input | AW | Address of the next byte after a flush |
| in_valid | input | 1 | Fetch byte valid |
| in_ready | output | 1 | Fetch byte accepted when high with in_valid |
| in_byte | input | 8 | Fetch byte |
| out_valid | output | 1 | Assembled instruction present |
| out_ready | input | 1 | Decoder takes the instruction |
| out_opcode | output | 8 | Opcode byte |
| out_operands | output | 32 | Operand bytes, byte k at bits [8k+7:8k], unused lanes zero |
| out_len | output | 3 | Instruction length in bytes (1, 2, 3 or 5) |
| out_disp_cls | output | 2 | Displacement source class |
| out_disp | output | DISP_W | Sign-extended displacement from operand bytes |
| out_addr | output | AW | Address of the opcode byte |

## Verification
A flush can arrive in the same cycle as the final operand byte of an instruction, or in the same cycle as the decoder accepting a waiting instruction. The bench drives both collisions. In the first case, the final byte is presented with `in_valid` during the flush. The check is that `in_ready` is low, that no instruction appears, and that the next byte decodes as an opcode at the flush address. In the second case, a completed instruction waits while flush and `out_ready` rise together. The check is that the output is dropped and that address tracking restarts at the target.

// File: rtl/ilp_pkg.sv
package ilp_pkg;
   localparam int OPC_W    = 8;
   localparam int MAX_OPND = 4;
   localparam int LEN_W    = 3;

   typedef enum logic [1:0] {
      DSP_STACK  = 2'd0,
      DSP_FIRST  = 2'd1,
      DSP_PAIR   = 2'd2,
      DSP_SECOND = 2'd3
   } disp_cls_e;
endpackage

// File: rtl/ilp_classify.sv
module ilp_classify
   import ilp_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output logic [LEN_W-1:0] len,
   output disp_cls_e        cls
);
   always_comb begin
      unique casez (opc[7:5])
         3'b000:  len = 3'd1;
         3'b001:  len = 3'd5;
         3'b01?:  len = 3'd1;
         3'b10?:  len = 3'd2;
         default: len = 3'd3;
      endcase
   end

   always_comb begin
      unique casez (opc[7:5])
         3'b0??:  cls = DSP_STACK;
         3'b10?:  cls = DSP_FIRST;
         3'b110:  cls = DSP_PAIR;
         default: cls = DSP_SECOND;
      endcase
   end
endmodule

// File: rtl/ilp_disp_ext.sv
module ilp_disp_ext
   import ilp_pkg::*;
#(
   parameter int DISP_W = 16
) (
   input  disp_cls_e                 cls,
   input  logic [8*MAX_OPND-1:0]     opnds,
   output logic [DISP_W-1:0]         disp
);
   localparam int BASE_W = 16;

   logic [BASE_W-1:0] base;

   always_comb begin
      unique case (cls)
         DSP_FIRST:  base = {{8{opnds[7]}}, opnds[7:0]};
         DSP_SECOND: base = {{8{opnds[15]}}, opnds[15:8]};
         DSP_PAIR:   base = {opnds[7:0], opnds[15:8]};
         default:    base = '0;
      endcase
   end

   generate
      if (DISP_W > BASE_W) begin : g_wide
         assign disp = {{(DISP_W-BASE_W){base[BASE_W-1]}}, base};
      end else begin : g_exact
         assign disp = base;
      end
   endgenerate

   logic unused_hi;
   assign unused_hi = ^opnds[8*MAX_OPND-1:16];
endmodule

// File: rtl/ilp_assembler.sv
module ilp_assembler
   import ilp_pkg::*;
#(
   parameter int             AW         = 16,
   parameter logic [AW-1:0]  RESET_ADDR = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic [AW-1:0]         flush_addr,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [OPC_W-1:0]      in_byte,
   input  logic [LEN_W-1:0]      new_len,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [OPC_W-1:0]      opc_q,
   output logic [8*MAX_OPND-1:0] opnds_q,
   output logic [AW-1:0]         addr_q
);
   localparam int IDX_W = $clog2(MAX_OPND);

   logic             busy_q;
   logic [LEN_W-1:0] left_q;
   logic [IDX_W-1:0] idx_q;
   logic [AW-1:0]    pc_q;
   logic             take;
   logic             start;

   assign in_ready = ~out_valid & ~flush;
   assign take     = in_valid & in_ready;
   assign start    = take & ~busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         left_q    <= '0;
         idx_q     <= '0;
         pc_q      <= RESET_ADDR;
         out_valid <= 1'b0;
         opc_q     <= '0;
         addr_q    <= '0;
      end else if (flush) begin
         busy_q    <= 1'b0;
         out_valid <= 1'b0;
         pc_q      <= flush_addr;
      end else begin
         if (out_valid && out_ready) out_valid <= 1'b0;
         if (take) begin
            pc_q <= pc_q + 1'b1;
            if (!busy_q) begin
               opc_q  <= in_byte;
               addr_q <= pc_q;
               idx_q  <= '0;
               if (new_len == 3'd1) begin
                  out_valid <= 1'b1;
               end else begin
                  busy_q <= 1'b1;
                  left_q <= new_len - 3'd1;
               end
            end else begin
               idx_q  <= idx_q + 1'b1;
               left_q <= left_q - 3'd1;
               if (left_q == 3'd1) begin
                  busy_q    <= 1'b0;
                  out_valid <= 1'b1;
               end
            end
         end
      end
   end

   generate
      for (genvar g = 0; g < MAX_OPND; g++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n || (start && !flush)) begin
               opnds_q[8*g +: 8] <= '0;
            end else if (take && busy_q && !flush && idx_q == IDX_W'(g)) begin
               opnds_q[8*g +: 8] <= in_byte;
            end
         end
      end
   endgenerate

   // R9
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !flush |=> out_valid && $stable(opc_q) && $stable(opnds_q) && $stable(addr_q));

   // R9
   stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R10
   flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid);

   // R8
   opcode_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !flush |=> out_valid || busy_q);
endmodule

// File: rtl/ilen_predecode.sv
module ilen_predecode
   import ilp_pkg::*;
#(
   parameter int             AW         = 16,
   parameter int             DISP_W     = 16,
   parameter logic [AW-1:0]  RESET_ADDR = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic [AW-1:0]         flush_addr,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [7:0]            in_byte,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [7:0]            out_opcode,
   output logic [31:0]           out_operands,
   output logic [2:0]            out_len,
   output logic [1:0]            out_disp_cls,
   output logic [DISP_W-1:0]     out_disp,
   output logic [AW-1:0]         out_addr
);
   generate
      if (AW < 8)       begin : g_bad_aw   $error("AW must be at least 8");      end
      if (DISP_W < 16)  begin : g_bad_disp $error("DISP_W must be at least 16"); end
   endgenerate

   logic [LEN_W-1:0] in_len;
   disp_cls_e        in_cls_unused;
   disp_cls_e        cls;

   ilp_classify u_cls_in (
      .opc (in_byte),
      .len (in_len),
      .cls (in_cls_unused)
   );

   ilp_assembler #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .flush_addr (flush_addr),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_byte    (in_byte),
      .new_len    (in_len),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .opc_q      (out_opcode),
      .opnds_q    (out_operands),
      .addr_q     (out_addr)
   );

   ilp_classify u_cls_out (
      .opc (out_opcode),
      .len (out_len),
      .cls (cls)
   );

   assign out_disp_cls = cls;

   ilp_disp_ext #(.DISP_W(DISP_W)) u_disp (
      .cls   (cls),
      .opnds (out_operands),
      .disp  (out_disp)
   );

   // R5
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_len == 3'd1 |-> out_operands == '0);

   // R5
   zero_fill_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_len != 3'd5 |-> out_operands[31:24] == '0);

   // R6
   stack_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_opcode[7] == 1'b0) == (out_disp_cls == 2'd0));

   // R7
   stack_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_disp_cls == 2'd0 |-> out_disp == '0);
endmodule

// File: tb/test_ilen_predecode.sv
`timescale 1ns/1ps
module test_ilen_predecode;
   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic [AW-1:0] flush_addr = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [7:0]    in_byte = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [7:0]    out_opcode;
   logic [31:0]   out_operands;
   logic [2:0]    out_len;
   logic [1:0]    out_disp_cls;
   logic [DW-1:0] out_disp;
   logic [AW-1:0] out_addr;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   logic [AW-1:0] exp_pc = '0;

   always #2 clk = ~clk;

   ilen_predecode #(.AW(AW), .DISP_W(DW)) i_ilen_predecode (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
      .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
      .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
      .out_operands(out_operands), .out_len(out_len), .out_disp_cls(out_disp_cls),
      .out_disp(out_disp), .out_addr(out_addr)
   );

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] e_len(logic [7:0] op);
      if (op[7:5] == 3'b001) return 3'd5;
      if (op[7] == 1'b0)     return 3'd1;
      if (op[6] == 1'b0)     return 3'd2;
      return 3'd3;
   endfunction

   function automatic logic [1:0] e_cls(logic [7:0] op);
      if (!op[7])        return 2'd0;
      if (!op[6])        return 2'd1;
      if (!op[5])        return 2'd2;
      return 2'd3;
   endfunction

   function automatic logic [15:0] e_disp(logic [7:0] op, logic [31:0] o);
      case (e_cls(op))
         2'd1:    return 16'($signed(o[7:0]));
         2'd2:    return {o[7:0], o[15:8]};
         2'd3:    return 16'($signed(o[15:8]));
         default: return 16'd0;
      endcase
   endfunction

   task automatic put_byte(logic [7:0] b);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
      exp_pc++;
   endtask

   task automatic send(logic [7:0] op, logic [31:0] o);
      put_byte(op);
      for (int k = 1; k < int'(e_len(op)); k++) put_byte(o[8*(k-1) +: 8]);
   endtask

   task automatic expect_out(string req, logic [7:0] op, logic [31:0] o,
                             logic [AW-1:0] a, bit take);
      logic [31:0] om;
      int n;
      n = int'(e_len(op)) - 1;
      om = (n == 4) ? o : (o & ((32'd1 << (8*n)) - 32'd1));
      for (int w = 0; w < 10 && !out_valid; w++) @(negedge clk);
      chk(req, "out_valid", out_valid, 1'b1);
      chk(req, "opcode", out_opcode, op);
      chk(req, "len", out_len, e_len(op));
      chk(req, "operands", out_operands, om);
      chk(req, "disp_cls", out_disp_cls, e_cls(op));
      chk(req, "disp", out_disp, e_disp(op, om));
      chk(req, "addr", out_addr, a);
      if (take) begin
         out_ready = 1'b1;
         @(negedge clk);
         out_ready = 1'b0;
         chk("R9", "valid after accept", out_valid, 1'b0);
      end
   endtask

   task automatic do_flush(logic [AW-1:0] a);
      @(negedge clk);
      flush = 1'b1;
      flush_addr = a;
      #0.5;
      chk("R10", "in_ready during flush", in_ready, 1'b0);
      @(negedge clk);
      flush = 1'b0;
      exp_pc = a;
      chk("R10", "out_valid after flush", out_valid, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1", "out_valid", out_valid, 1'b0);
      chk("R1", "in_ready", in_ready, 1'b1);
   endtask

   task automatic t_short();
      logic [AW-1:0] a;
      a = exp_pc; send(8'h05, 0); expect_out("R1 R2", 8'h05, 0, a, 1);
      a = exp_pc; send(8'h45, 0); expect_out("R2 R8", 8'h45, 0, a, 1);
      a = exp_pc; send(8'h7F, 0); expect_out("R2 R6", 8'h7F, 0, a, 1);
   endtask

   task automatic t_multi();
      logic [AW-1:0] a;
      a = exp_pc; send(8'h9A, 32'h000000F0); expect_out("R4 R7", 8'h9A, 32'hF0, a, 1);
      a = exp_pc; send(8'hC5, 32'h00003412); expect_out("R4 R7 pair", 8'hC5, 32'h3412, a, 1);
      a = exp_pc; send(8'hE0, 32'h00008511); expect_out("R4 R7 second", 8'hE0, 32'h8511, a, 1);
      a = exp_pc; send(8'h22, 32'h44332211); expect_out("R3", 8'h22, 32'h44332211, a, 1);
      a = exp_pc; send(8'h81, 32'h0000007F); expect_out("R5 R8", 8'h81, 32'h7F, a, 1);
   endtask

   task automatic t_hold();
      logic [AW-1:0] a;
      a = exp_pc;
      send(8'hB3, 32'h00000002);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R9", "in_ready held low", in_ready, 1'b0);
      end
      in_valid = 1'b1; in_byte = 8'h10;
      @(negedge clk);
      in_valid = 1'b0;
      expect_out("R9 hold", 8'hB3, 32'h02, a, 1);
   endtask

   task automatic t_flush_partial();
      put_byte(8'h25); put_byte(8'hAA);
      do_flush(16'h0100);
      send(8'h41, 0);
      expect_out("R10 partial", 8'h41, 0, 16'h0100, 1);
   endtask

   task automatic t_flush_last_byte();
      put_byte(8'hC0); put_byte(8'h11);
      @(negedge clk);
      flush = 1'b1; flush_addr = 16'h0200;
      in_valid = 1'b1; in_byte = 8'h22;
      #0.5;
      chk("R10", "in_ready with last byte", in_ready, 1'b0);
      @(negedge clk);
      flush = 1'b0; in_valid = 1'b0;
      exp_pc = 16'h0200;
      @(negedge clk);
      chk("R10", "no output after collision", out_valid, 1'b0);
      send(8'h88, 32'h000000FE);
      expect_out("R10 collision", 8'h88, 32'hFE, 16'h0200, 1);
   endtask

   task automatic t_flush_pending();
      send(8'h80, 32'h00000001);
      @(negedge clk);
      chk("R9", "pending valid", out_valid, 1'b1);
      flush = 1'b1; flush_addr = 16'h0300; out_ready = 1'b1;
      @(negedge clk);
      flush = 1'b0; out_ready = 1'b0;
      exp_pc = 16'h0300;
      chk("R10", "pending dropped", out_valid, 1'b0);
      send(8'h33, 32'hDDCCBBAA);
      expect_out("R10 pending", 8'h33, 32'hDDCCBBAA, 16'h0300, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short();
      t_multi();
      t_hold();
      t_flush_partial();
      t_flush_last_byte();
      t_flush_pending();
      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule